// File: doc/BRIEF.md
# Console Reset Sequencer with Pulse Stretcher

This block produces the active-low processor reset and the active-high expansion reset for a retro console. It takes three inputs: a power-good level from an external comparator, which is asynchronous and marks a cold boot when it rises; a raw reset-button level with no debouncing; and a single-cycle request that the CPU raises when it executes its reset instruction. All timing is counted in cycles of the one system clock.

When power-good rises, the expansion reset drops at once. The processor reset is held for a long fixed interval, made of a number of prescaler periods, and then released. After that, a button press or a CPU request gives one clean processor reset pulse of fixed width. A button press waits at least a minimum number of cycles and then lines up with the next boundary of a free-running prescaler. Contact bounce cannot split, shorten or stretch a pulse. When power-good falls, the expansion reset rises at once. The processor reset follows after a fixed lag.

Top module: `console_rst_seq`

## Requirements
- R1: While `rst` is high, `cpu_rst_n` is 0 and `exp_rst` is 1.
- R2: After `pwr_good_in` goes high, `cpu_rst_n` rises on the rising clock edge that comes PRESC_CYC*COLD_TICKS edges after the synchronized power-good rises. The synchronized level changes on the second edge after the input changes.
- R3: `exp_rst` is the inverse of the two-flop-synchronized power-good. It falls on the second clock edge after `pwr_good_in` rises and rises on the second edge after it falls.
- R4: After a fall of the synchronized power-good that finds the processor out of reset, `cpu_rst_n` stays 1 for PDOWN_CYC cycles and then falls.
- R5: While power-good is low, and during the cold-boot hold, `cpu_rst_n` is held 0. Button edges and CPU requests that arrive then are discarded and leave no pending pulse.
- R6: A synchronized button rising edge starts a wait. The pulse then starts on an edge that comes at least BTN_MIN_CYC cycles after the press. That edge is a prescaler boundary: the number of clock edges since `rst` fell is a multiple of PRESC_CYC.
- R7: Every pulse from the button or from a CPU request holds `cpu_rst_n` at 0 for exactly PULSE_CYC cycles. A button press never re-runs the cold-boot hold.
- R8: Button activity during the wait or during a pulse neither splits, shortens nor lengthens the pulse. Only one pulse results, unless a new rising edge comes after the pulse ends.
- R9: When `cpu_rst_req` is 1 on an edge while the processor is running, `cpu_rst_n` falls on that same edge for PULSE_CYC cycles. `exp_rst` is not affected. A request that arrives during a pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good_in | input | 1 | Asynchronous power-good level, 1 = supply good |
| btn_in | input | 1 | Raw reset-button level, 1 = pressed, may bounce |
| cpu_rst_req | input | 1 | Reset-instruction request, synchronous to clk |
| cpu_rst_n | output | 1 | Processor reset, active low |
| exp_rst | output | 1 | Expansion reset, active high |

## Verification
The bench builds the block with PULSE_CYC=128, PRESC_CYC=24, COLD_TICKS=10 (a cold hold of 240 cycles), BTN_MIN_CYC=150 and PDOWN_CYC=60. With these short intervals, the exact cold-boot release and the exact power-down lag can be counted edge by edge more than once. The prescaler phase at each button-pulse start can be checked against the bench's own edge count. Many bouncing presses of random length also fit in the run, and their bounce spans reach into the pulse itself.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_COLD,
        ST_RUN,
        ST_BTN_WAIT,
        ST_PULSE,
        ST_PDOWN
    } rseq_state_e;

    // Per-cycle events presented to the sequencer
    typedef struct packed {
        logic pg_lvl;
        logic btn_rise;
        logic cpu_req;
        logic presc_tick;
    } rseq_evt_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // States in which the processor is held in reset
    function automatic logic holds_low(input rseq_state_e s);
        return (s == ST_OFF) || (s == ST_COLD) || (s == ST_PULSE);
    endfunction

endpackage

// File: rtl/rseq_sync2.sv
module rseq_sync2 #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d[g];
                sync_q <= meta_q;
            end
        end
        assign q[g] = sync_q;
    end

endmodule

// File: rtl/rseq_presc.sv
module rseq_presc #(
    parameter int DIV = 384
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + W'(1);
    end

    assign tick = (cnt_q == LAST);

    // R6
    presc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (cnt_q == '0));

endmodule

// File: rtl/rseq_fsm.sv
module rseq_fsm
    import rseq_pkg::*;
#(
    parameter int PULSE_CYC   = 128,
    parameter int COLD_CYC    = 98304,
    parameter int BTN_MIN_CYC = 16384,
    parameter int PDOWN_CYC   = 19231
) (
    input  logic      clk,
    input  logic      rst,
    input  rseq_evt_t evt,
    output logic      cpu_rst_n
);

    localparam int unsigned CNT_MAX = max2(max2(PULSE_CYC, COLD_CYC),
                                           max2(BTN_MIN_CYC, PDOWN_CYC));
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    // Hold and lag are measured from the edge on which the synchronized
    // level changed; the sequencer sees that change one edge later.
    localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] COLD_END  = CNT_W'(COLD_CYC - 2);
    localparam logic [CNT_W-1:0] PDOWN_END = CNT_W'(PDOWN_CYC - 2);
    localparam logic [CNT_W-1:0] MIN_END   = CNT_W'(BTN_MIN_CYC - 1);

    rseq_state_e      state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q + CNT_W'(1);
        unique case (state_q)
            ST_OFF: begin
                cnt_n = '0;
                if (evt.pg_lvl) state_n = ST_COLD;
            end
            ST_COLD: begin
                if (!evt.pg_lvl) begin
                    state_n = ST_OFF;
                    cnt_n   = '0;
                end else if (cnt_q == COLD_END) begin
                    state_n = ST_RUN;
                    cnt_n   = '0;
                end
            end
            ST_RUN: begin
                cnt_n = '0;
                if (!evt.pg_lvl)       state_n = ST_PDOWN;
                else if (evt.btn_rise) state_n = ST_BTN_WAIT;
                else if (evt.cpu_req)  state_n = ST_PULSE;
            end
            ST_BTN_WAIT: begin
                if (!evt.pg_lvl) begin
                    state_n = ST_PDOWN;
                    cnt_n   = '0;
                end else if (cnt_q >= MIN_END) begin
                    cnt_n = cnt_q;
                    if (evt.presc_tick) begin
                        state_n = ST_PULSE;
                        cnt_n   = '0;
                    end
                end
            end
            ST_PULSE: begin
                if (!evt.pg_lvl) begin
                    state_n = ST_OFF;
                    cnt_n   = '0;
                end else if (cnt_q == PULSE_END) begin
                    state_n = ST_RUN;
                    cnt_n   = '0;
                end
            end
            ST_PDOWN: begin
                if (cnt_q == PDOWN_END) begin
                    state_n = ST_OFF;
                    cnt_n   = '0;
                end
            end
            default: begin
                state_n = ST_OFF;
                cnt_n   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_OFF;
            cnt_q     <= '0;
            cpu_rst_n <= 1'b0;
        end else begin
            state_q   <= state_n;
            cnt_q     <= cnt_n;
            cpu_rst_n <= !holds_low(state_n);
        end
    end

    // R5
    off_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OFF) |-> !cpu_rst_n);

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PULSE && cnt_q < PULSE_END && evt.pg_lvl)
        |=> (state_q == ST_PULSE && !cpu_rst_n));

    // R8
    wait_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BTN_WAIT && evt.pg_lvl && !evt.presc_tick)
        |=> (state_q == ST_BTN_WAIT && cpu_rst_n));

    // R6
    pulse_align_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == ST_BTN_WAIT && state_q == ST_PULSE)
        |-> ($past(evt.presc_tick) && $past(cnt_q) >= MIN_END));

    // R7
    cold_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_COLD)
        |-> ($past(state_q) == ST_OFF || $past(state_q) == ST_COLD));

    // R4
    pdown_high_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PDOWN) |-> cpu_rst_n);

endmodule

// File: rtl/console_rst_seq.sv
module console_rst_seq
    import rseq_pkg::*;
#(
    parameter int PULSE_CYC   = 128,
    parameter int PRESC_CYC   = 384,
    parameter int COLD_TICKS  = 256,
    parameter int BTN_MIN_CYC = 16384,
    parameter int PDOWN_CYC   = 19231
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good_in,
    input  logic btn_in,
    input  logic cpu_rst_req,
    output logic cpu_rst_n,
    output logic exp_rst
);

    localparam int COLD_CYC = PRESC_CYC * COLD_TICKS;
    localparam int SYNC_W   = 2;

    logic [SYNC_W-1:0] sync_v;
    logic              pg_s;
    logic              btn_s;
    logic              btn_d_q;
    logic              tick;
    rseq_evt_t         evt;

    rseq_sync2 #(.WIDTH(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pwr_good_in, btn_in}),
        .q   (sync_v)
    );

    assign pg_s  = sync_v[1];
    assign btn_s = sync_v[0];

    always_ff @(posedge clk) begin
        if (rst) btn_d_q <= 1'b0;
        else     btn_d_q <= btn_s;
    end

    rseq_presc #(.DIV(PRESC_CYC)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    always_comb begin
        evt.pg_lvl     = pg_s;
        evt.btn_rise   = btn_s && !btn_d_q;
        evt.cpu_req    = cpu_rst_req;
        evt.presc_tick = tick;
    end

    rseq_fsm #(
        .PULSE_CYC   (PULSE_CYC),
        .COLD_CYC    (COLD_CYC),
        .BTN_MIN_CYC (BTN_MIN_CYC),
        .PDOWN_CYC   (PDOWN_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .cpu_rst_n (cpu_rst_n)
    );

    assign exp_rst = !pg_s;

    // R3
    exp_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(exp_rst) |-> !cpu_rst_n);

endmodule

// File: tb/console_rst_seq_bench.sv
module console_rst_seq_bench;

    localparam int PULSE = 128;
    localparam int PRESC = 24;
    localparam int TICKS = 10;
    localparam int COLD  = PRESC * TICKS;
    localparam int MINC  = 150;
    localparam int LAG   = 60;

    logic clk = 1'b0;
    logic rst, pwr_good_in, btn_in, cpu_rst_req;
    logic cpu_rst_n, exp_rst;
    int   total = 0, fails = 0, pc = 0;
    bit   done = 0;

    always #5 clk = ~clk;

    always @(posedge clk) pc <= rst ? 0 : pc + 1;

    console_rst_seq #(
        .PULSE_CYC(PULSE), .PRESC_CYC(PRESC), .COLD_TICKS(TICKS),
        .BTN_MIN_CYC(MINC), .PDOWN_CYC(LAG)
    ) u_console_rst_seq (
        .clk(clk), .rst(rst), .pwr_good_in(pwr_good_in), .btn_in(btn_in),
        .cpu_rst_req(cpu_rst_req), .cpu_rst_n(cpu_rst_n), .exp_rst(exp_rst)
    );

    function automatic int cold_release_idx(); return 2 + COLD; endfunction
    function automatic int lag_idx();          return 2 + LAG;  endfunction
    function automatic int btn_earliest();     return MINC;     endfunction
    function automatic int btn_latest();       return MINC + PRESC + 2; endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold_check(input int n, input logic val, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (cpu_rst_n !== val) bad++;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic power_up(input bit press);
        @(negedge clk);
        pwr_good_in = 1'b1;
        for (int i = 1; i <= cold_release_idx(); i++) begin
            @(negedge clk);
            if (i == 1) chk(exp_rst === 1'b1, "R3 exp before sync", exp_rst, 1);
            if (i == 2) chk(exp_rst === 1'b0, "R3 exp release", exp_rst, 0);
            if (press && i == 10) btn_in = 1'b1;
            if (press && i == 14) btn_in = 1'b0;
            if (i == cold_release_idx() - 1)
                chk(cpu_rst_n === 1'b0, "R2 still held", cpu_rst_n, 0);
            if (i == cold_release_idx())
                chk(cpu_rst_n === 1'b1, "R2 release edge", cpu_rst_n, 1);
        end
        if (press) hold_check(MINC + PRESC + PULSE, 1'b1, "R5 press in hold dropped");
    endtask

    task automatic power_down();
        @(negedge clk);
        pwr_good_in = 1'b0;
        for (int i = 1; i <= lag_idx(); i++) begin
            @(negedge clk);
            if (i == 1) chk(exp_rst === 1'b0, "R3 exp before sync", exp_rst, 0);
            if (i == 2) chk(exp_rst === 1'b1, "R3 exp assert", exp_rst, 1);
            if (i == lag_idx() - 1) chk(cpu_rst_n === 1'b1, "R4 lag high", cpu_rst_n, 1);
            if (i == lag_idx())     chk(cpu_rst_n === 1'b0, "R4 lag end", cpu_rst_n, 0);
        end
    endtask

    task automatic btn_trial(input int bounce);
        int   fall_i = -1, rise_i = -1, falls = 0, phase = -1;
        logic prev;
        @(negedge clk);
        btn_in = 1'b1;
        prev = cpu_rst_n;
        for (int i = 1; i <= MINC + PRESC + PULSE + 40; i++) begin
            @(negedge clk);
            if (prev && !cpu_rst_n) begin
                falls++;
                if (fall_i < 0) begin fall_i = i; phase = pc % PRESC; end
            end
            if (!prev && cpu_rst_n && rise_i < 0) rise_i = i;
            prev = cpu_rst_n;
            btn_in = (i < bounce) ? 1'($urandom % 2) : 1'b1;
        end
        chk(fall_i >= btn_earliest() && fall_i <= btn_latest(), "R6 delay", fall_i, btn_earliest());
        chk(phase == 0, "R6 prescaler boundary", phase, 0);
        chk(falls == 1, "R8 single pulse", falls, 1);
        chk(rise_i - fall_i == PULSE, "R7 width", rise_i - fall_i, PULSE);
        btn_in = 1'b0;
        hold_check(40, 1'b1, "R8 no extra pulse");
    endtask

    task automatic cpu_trial(input bit mid);
        int bad = 0, xbad = 0;
        @(negedge clk);
        cpu_rst_req = 1'b1;
        for (int i = 1; i <= PULSE + 1; i++) begin
            @(negedge clk);
            cpu_rst_req = (mid && i == PULSE / 2) ? 1'b1 : 1'b0;
            if (i <= PULSE && cpu_rst_n !== 1'b0) bad++;
            if (i == PULSE + 1 && cpu_rst_n !== 1'b1) bad++;
            if (exp_rst !== 1'b0) xbad++;
        end
        chk(bad == 0, "R9 cpu pulse width", bad, 0);
        chk(xbad == 0, "R9 exp untouched", xbad, 0);
        hold_check(20, 1'b1, mid ? "R9 request in pulse ignored" : "R9 no extra pulse");
    endtask

    initial begin
        void'($urandom(32'h5EED));
        rst = 1'b1; pwr_good_in = 1'b0; btn_in = 1'b0; cpu_rst_req = 1'b0;
        repeat (5) @(negedge clk);
        chk(cpu_rst_n === 1'b0, "R1 cpu_rst_n", cpu_rst_n, 0);
        chk(exp_rst === 1'b1, "R1 exp_rst", exp_rst, 1);
        rst = 1'b0;
        // R5: requests with power-good low
        btn_in = 1'b1; cpu_rst_req = 1'b1;
        @(negedge clk);
        cpu_rst_req = 1'b0;
        hold_check(30, 1'b0, "R5 held while power low");
        btn_in = 1'b0;
        repeat (4) @(negedge clk);
        power_up(1'b1);
        for (int t = 0; t < 6; t++) btn_trial(1 + int'($urandom % (MINC + 60)));
        for (int t = 0; t < 5; t++) begin
            repeat (1 + $urandom % 30) @(negedge clk);
            cpu_trial(t == 2);
        end
        power_down();
        btn_in = 1'b1; cpu_rst_req = 1'b1;
        @(negedge clk);
        cpu_rst_req = 1'b0;
        hold_check(50, 1'b0, "R5 ignored after power down");
        btn_in = 1'b0;
        repeat (4) @(negedge clk);
        power_up(1'b0);
        // R7: press after second boot gives a short pulse, not a cold hold
        btn_trial(1);
        btn_trial(MINC + 40);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #(150000 * 10);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule